// File: doc/BRIEF.md
# PWM-Synchronous Shunt Current Demodulator

This block turns an AC-coupled stream of filtered ADC words from two bridge shunts back into a signed winding-current value. The coupling capacitor removes the DC level of each shunt signal. The conduction pattern of the bridge still modulates that level at the PWM rate. The block restores it by synchronous rectification. Each accepted sample is added with a positive sign while its channel's shunt carries current, and with a negative sign while it does not.

The PWM sequencer supplies three things: the present bridge state, a strobe on every state change, and a strobe at the carrier valley. The valley strobe marks the period boundary. The block discards the samples that follow each switching event, because they contain filter settling and switching noise. At each valley it closes the period and divides each channel's signed sum by the number of samples it accepted. It then presents one averaged value per channel together with that sample count. When no switching event occurred within a period, the drive state filled the whole period. In that case, or when no samples were accepted, demodulation is not possible. The block raises a flag and forces both results to zero.

Top module: `cur_sync_demod`

## Requirements
- R1: After reset, res_valid, no_demod, res_cnt, res_a and res_b are all zero.
- R2: Channel A's sign is +1 when bridge_st is 1 (low free-wheel), or when bridge_st is 0 (drive) with drv_pol=0. Channel B's sign is +1 when bridge_st is 2 (high free-wheel), or when bridge_st is 0 with drv_pol=1. In every other case the sign is -1, and bridge_st 3 gives -1 on both channels.
- R3: The sample presented in a cycle with state_chg high is discarded. So are the next BLANK (default 3) valid samples after that cycle. A new state_chg restarts the discard count.
- R4: A cycle with valley high closes the period. The accepted sample in that cycle, and any state_chg in that cycle, belong to the new period, which starts from an empty sum and a zero count.
- R5: For a closed period, res_a and res_b equal the signed sum divided by the accepted count, truncated toward zero. res_cnt equals the accepted count. res_valid is high for exactly one cycle: the (ACC_W+2)-th cycle after the valley cycle, which is cycle 28 with the default widths.
- R6: no_demod is 1, and both results are 0, for a period that saw no state_chg or that accepted no samples. Otherwise no_demod is 0.
- R7: The accepted count stops at 2^CNT_W-1 (1023 by default). Samples beyond that limit are left out of both the sum and the count.
- R8: Both channels use identical datapaths and report in the same cycle. Equal input words under opposite signs give results of equal magnitude and opposite sign.
- R9: Cycles with smp_valid low add nothing to the sum or the count, and they do not advance the discard count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A new sample word is present on both channels |
| smp_a | input | SMP_W | Signed filtered sample, shunt channel A |
| smp_b | input | SMP_W | Signed filtered sample, shunt channel B |
| bridge_st | input | 2 | Present bridge state: 0 drive, 1 low free-wheel, 2 high free-wheel, 3 off |
| drv_pol | input | 1 | Drive polarity during state 0 |
| state_chg | input | 1 | Strobe on every bridge state change |
| valley | input | 1 | Carrier valley strobe; closes the period |
| res_valid | output | 1 | One-cycle pulse with new results |
| res_a | output | SMP_W+1 | Averaged signed current, channel A |
| res_b | output | SMP_W+1 | Averaged signed current, channel B |
| res_cnt | output | CNT_W | Samples accepted in the reported period |
| no_demod | output | 1 | Period could not be demodulated |

## Verification
The period boundary and the blanking logic can both act in one cycle, and the period boundary can also coincide with an accepted sample. Directed tests provoke both cases. They drive valley together with a valid sample and, in a separate case, valley together with state_chg. The next period's reported sum and count then show whether the sample or the strobe was carried into the new period. Tests of count saturation and zero-count periods check the other boundary behaviour.

// File: rtl/cdm_pkg.sv
package cdm_pkg;

   typedef enum logic [1:0] {
      BR_DRIVE   = 2'd0,
      BR_FW_LOW  = 2'd1,
      BR_FW_HIGH = 2'd2,
      BR_OFF     = 2'd3
   } br_state_e;

   // Whether the shunt of channel ch (0 = A, 1 = B) carries current.
   function automatic logic shunt_on(input logic [1:0] st, input logic pol, input int ch);
      br_state_e s;
      s = br_state_e'(st);
      if (ch == 0) return (s == BR_FW_LOW)  || (s == BR_DRIVE && !pol);
      else         return (s == BR_FW_HIGH) || (s == BR_DRIVE &&  pol);
   endfunction

endpackage

// File: rtl/cdm_blank.sv
module cdm_blank #(
   parameter int BLANK = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_valid,
   input  logic state_chg,
   output logic accept
);
   localparam int BL_W = $clog2(BLANK + 1);

   logic [BL_W-1:0] left_q;

   assign accept = smp_valid && !state_chg && (left_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         left_q <= '0;
      else if (state_chg)
         left_q <= BL_W'(BLANK);
      else if (smp_valid && left_q != '0)
         left_q <= left_q - 1'b1;
   end
endmodule

// File: rtl/cdm_acc.sv
module cdm_acc #(
   parameter int SMP_W = 16,
   parameter int ACC_W = 26
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    valley,
   input  logic                    take,
   input  logic                    pos,
   input  logic signed [SMP_W-1:0] smp,
   output logic signed [ACC_W-1:0] sum
);
   logic signed [ACC_W-1:0] ext, term;

   assign ext  = ACC_W'(smp);
   assign term = pos ? ext : -ext;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sum <= '0;
      else if (valley)
         sum <= take ? term : '0;
      else if (take)
         sum <= sum + term;
   end
endmodule

// File: rtl/cdm_div.sv
module cdm_div #(
   parameter int NUM_W = 26,
   parameter int DEN_W = 10,
   parameter int OUT_W = 17
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic signed [NUM_W-1:0] num,
   input  logic [DEN_W-1:0]        den,
   output logic                    done,
   output logic signed [OUT_W-1:0] quo
);
   localparam int IT_W = $clog2(NUM_W + 1);

   logic             busy, neg;
   logic [IT_W-1:0]  it;
   logic [NUM_W-1:0] dvd;
   logic [DEN_W-1:0] rem, den_q;
   logic [DEN_W:0]   trial;
   logic             fits;
   logic [OUT_W-2:0] mag;

   assign trial = {rem, dvd[NUM_W-1]};
   assign fits  = trial >= {1'b0, den_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         neg   <= 1'b0;
         it    <= '0;
         dvd   <= '0;
         rem   <= '0;
         den_q <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy  <= 1'b1;
            neg   <= num[NUM_W-1];
            dvd   <= num[NUM_W-1] ? NUM_W'(-num) : NUM_W'(num);
            rem   <= '0;
            den_q <= den;
            it    <= IT_W'(NUM_W);
         end else if (busy) begin
            rem <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
            dvd <= {dvd[NUM_W-2:0], fits};
            it  <= it - 1'b1;
            if (it == IT_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // Defensive clip: the average magnitude never exceeds 2^(OUT_W-2).
   assign mag = (|dvd[NUM_W-1:OUT_W-1]) ? '1 : dvd[OUT_W-2:0];
   assign quo = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
endmodule

// File: rtl/cur_sync_demod.sv
module cur_sync_demod #(
   parameter int SMP_W = 16,
   parameter int CNT_W = 10,
   parameter int BLANK = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_valid,
   input  logic signed [SMP_W-1:0] smp_a,
   input  logic signed [SMP_W-1:0] smp_b,
   input  logic [1:0]              bridge_st,
   input  logic                    drv_pol,
   input  logic                    state_chg,
   input  logic                    valley,
   output logic                    res_valid,
   output logic signed [SMP_W:0]   res_a,
   output logic signed [SMP_W:0]   res_b,
   output logic [CNT_W-1:0]        res_cnt,
   output logic                    no_demod
);
   import cdm_pkg::*;

   localparam int ACC_W   = SMP_W + CNT_W;
   localparam int OUT_W   = SMP_W + 1;
   localparam int NCH     = 2;
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   if (SMP_W < 2)  begin : g_bad_smp   $error("SMP_W must be at least 2");  end
   if (CNT_W < 2)  begin : g_bad_cnt   $error("CNT_W must be at least 2");  end
   if (BLANK < 1)  begin : g_bad_blank $error("BLANK must be at least 1"); end

   logic                    accept, take, full;
   logic [CNT_W-1:0]        cnt_q, cnt_pend;
   logic                    chg_seen, nd_pend;
   logic signed [SMP_W-1:0] smp   [NCH];
   logic signed [ACC_W-1:0] sum   [NCH];
   logic signed [OUT_W-1:0] quo   [NCH];
   logic [NCH-1:0]          done;

   assign smp[0] = smp_a;
   assign smp[1] = smp_b;
   assign full   = cnt_q == CNT_W'(CNT_MAX);
   assign take   = accept && (valley || !full);

   cdm_blank #(.BLANK(BLANK)) u_blank (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .state_chg(state_chg), .accept(accept)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic pos;
      assign pos = shunt_on(bridge_st, drv_pol, c);

      cdm_acc #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_acc (
         .clk(clk), .rst_n(rst_n), .valley(valley), .take(take),
         .pos(pos), .smp(smp[c]), .sum(sum[c])
      );

      cdm_div #(.NUM_W(ACC_W), .DEN_W(CNT_W), .OUT_W(OUT_W)) u_div (
         .clk(clk), .rst_n(rst_n), .start(valley), .num(sum[c]),
         .den(cnt_q), .done(done[c]), .quo(quo[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         chg_seen <= 1'b0;
         cnt_pend <= '0;
         nd_pend  <= 1'b0;
      end else if (valley) begin
         cnt_pend <= cnt_q;
         nd_pend  <= !chg_seen || (cnt_q == '0);
         cnt_q    <= take ? CNT_W'(1) : '0;
         chg_seen <= state_chg;
      end else begin
         if (take) cnt_q <= cnt_q + 1'b1;
         if (state_chg) chg_seen <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_a     <= '0;
         res_b     <= '0;
         res_cnt   <= '0;
         no_demod  <= 1'b0;
      end else begin
         res_valid <= done[0];
         if (done[0]) begin
            res_a    <= nd_pend ? '0 : quo[0];
            res_b    <= nd_pend ? '0 : quo[1];
            res_cnt  <= cnt_pend;
            no_demod <= nd_pend;
         end
      end
   end
endmodule

// File: rtl/cdm_chk.sv
module cdm_chk #(
   parameter int SMP_W = 16,
   parameter int CNT_W = 10
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  state_chg,
   input logic                  valley,
   input logic                  accept,
   input logic [1:0]            done,
   input logic [CNT_W-1:0]      cnt_q,
   input logic                  res_valid,
   input logic                  no_demod,
   input logic signed [SMP_W:0] res_a,
   input logic signed [SMP_W:0] res_b
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   assert_blank_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      state_chg |-> !accept);

   assert_blank_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      state_chg |=> !accept);

   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   assert_nodemod_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && no_demod) |-> (res_a == '0 && res_b == '0));

   assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!valley && cnt_q == CMAX) |=> cnt_q == CMAX);

   assert_count_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      valley |=> cnt_q <= CNT_W'(1));

   assert_chan_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done[0] == done[1]);
endmodule

bind cur_sync_demod cdm_chk #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .state_chg(state_chg), .valley(valley),
   .accept(accept), .done(done), .cnt_q(cnt_q), .res_valid(res_valid),
   .no_demod(no_demod), .res_a(res_a), .res_b(res_b)
);

// File: tb/tb_cur_sync_demod.sv
module tb_cur_sync_demod;
   localparam int SMP_W = 16;
   localparam int CNT_W = 10;
   localparam int BLANK = 3;
   localparam int ACC_W = SMP_W + CNT_W;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic signed [SMP_W-1:0] smp_a = '0, smp_b = '0;
   logic [1:0] bridge_st = 2'd0;
   logic drv_pol = 1'b0, state_chg = 1'b0, valley = 1'b0;
   logic res_valid, no_demod;
   logic signed [SMP_W:0] res_a, res_b;
   logic [CNT_W-1:0] res_cnt;

   int errors = 0, checks = 0;
   bit done_flag = 0;

   // bench model state, derived from the requirements
   longint m_sa = 0, m_sb = 0, s_sa = 0, s_sb = 0;
   int m_n = 0, s_n = 0, m_bl = 0;
   bit m_chg = 0, s_chg = 0;

   always #2 clk = ~clk;

   cur_sync_demod #(.SMP_W(SMP_W), .CNT_W(CNT_W), .BLANK(BLANK)) dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
      .bridge_st(bridge_st), .drv_pol(drv_pol), .state_chg(state_chg), .valley(valley),
      .res_valid(res_valid), .res_a(res_a), .res_b(res_b), .res_cnt(res_cnt),
      .no_demod(no_demod)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sgn(input logic [1:0] st, input logic pol, input int ch);
      // R2 sign table
      if (ch == 0) return (st == 2'd1 || (st == 2'd0 && !pol)) ? 1 : -1;
      return (st == 2'd2 || (st == 2'd0 && pol)) ? 1 : -1;
   endfunction

   // One cycle of stimulus, model updated per R2/R3/R4/R7/R9.
   task automatic cyc(input logic [1:0] st, input logic pol, input logic v,
                      input int a, input int b, input logic chg, input logic vy);
      bit acc;
      bridge_st = st; drv_pol = pol; smp_valid = v;
      smp_a = SMP_W'(a); smp_b = SMP_W'(b); state_chg = chg; valley = vy;
      acc = v && !chg && m_bl == 0;
      if (chg) m_bl = BLANK; else if (v && m_bl > 0) m_bl--;
      if (vy) begin
         s_sa = m_sa; s_sb = m_sb; s_n = m_n; s_chg = m_chg;
         m_sa = acc ? longint'(sgn(st, pol, 0) * a) : 0;
         m_sb = acc ? longint'(sgn(st, pol, 1) * b) : 0;
         m_n = acc ? 1 : 0; m_chg = chg;
      end else begin
         if (acc && m_n < CMAX) begin
            m_sa += sgn(st, pol, 0) * a; m_sb += sgn(st, pol, 1) * b; m_n++;
         end
         if (chg) m_chg = 1;
      end
      @(negedge clk);
      smp_valid = 0; state_chg = 0; valley = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(bridge_st, drv_pol, 0, 0, 0, 0, 0);
   endtask

   // Close the period with the given valley-cycle stimulus and check results.
   task automatic close(input string tag, input logic [1:0] st, input logic v,
                        input int a, input int b, input logic chg);
      int n;
      bit nd;
      longint ea, eb;
      cyc(st, drv_pol, v, a, b, chg, 1);
      n = 1;
      while (!res_valid && n < 100) begin
         @(negedge clk); n++;
      end
      nd = !s_chg || s_n == 0;
      ea = nd ? 0 : s_sa / s_n;
      eb = nd ? 0 : s_sb / s_n;
      check(n == ACC_W + 2, {tag, " R5 latency"}, n, ACC_W + 2);
      check(res_a == ea, {tag, " R5 res_a"}, res_a, ea);
      check(res_b == eb, {tag, " R5 res_b"}, res_b, eb);
      check(res_cnt == s_n, {tag, " R5 res_cnt"}, res_cnt, s_n);
      check(no_demod == nd, {tag, " R6 no_demod"}, no_demod, nd);
      @(negedge clk);
      check(res_valid == 0, {tag, " R5 pulse width"}, res_valid, 0);
   endtask

   task automatic t_reset();
      check(res_valid == 0 && no_demod == 0, "R1 flags", {res_valid, no_demod}, 0);
      check(res_a == 0 && res_b == 0 && res_cnt == 0, "R1 values", res_a, 0);
   endtask

   task automatic t_basic();
      // R2 low free-wheel: A positive, B negative; R3 blanking of 3 samples
      cyc(2'd1, 0, 1, 999, 999, 1, 0);
      for (int i = 0; i < 3; i++) cyc(2'd1, 0, 1, 5000, 5000, 0, 0);
      for (int i = 0; i < 8; i++) cyc(2'd1, 0, 1, 100, 50, 0, 0);
      close("basic", 2'd1, 0, 0, 0, 0);
      check(s_n == 8, "R3 model count", s_n, 8);
   endtask

   task automatic t_mixed();
      // R2 over all states, R9 invalid gaps during blanking, R5 truncation
      cyc(2'd0, 0, 1, 7, 7, 1, 0);
      cyc(2'd0, 0, 0, 9999, 9999, 0, 0);
      for (int i = 0; i < 3; i++) cyc(2'd0, 0, 1, 3000, 3000, 0, 0);
      cyc(2'd0, 0, 1, 10, -3, 0, 0);
      cyc(2'd2, 0, 1, -7, 4, 1, 0);
      for (int i = 0; i < 3; i++) cyc(2'd2, 0, 0, 1234, 1234, 0, 0);
      for (int i = 0; i < 3; i++) cyc(2'd2, 0, 1, 0, 0, 0, 0);
      cyc(2'd2, 0, 1, 11, -6, 0, 0);
      cyc(2'd2, 0, 1, 4, 9, 0, 0);
      cyc(2'd3, 0, 1, 2, 2, 0, 0);
      cyc(2'd0, 1, 1, -32768, -32768, 0, 0);
      close("mixed", 2'd0, 0, 0, 0, 0);
   endtask

   task automatic t_same_cycle();
      // R4: valley with an accepted sample, then valley with state_chg
      cyc(2'd1, 0, 1, 1, 1, 1, 0);
      for (int i = 0; i < 3; i++) cyc(2'd1, 0, 1, 0, 0, 0, 0);
      cyc(2'd1, 0, 1, 40, 40, 0, 0);
      close("vy_smp_a", 2'd1, 1, 300, 300, 0);
      idle(2);
      close("vy_smp_b", 2'd1, 0, 0, 0, 1);
      check(s_n == 1 && s_chg == 0, "R4 valley sample carried", s_n, 1);
      for (int i = 0; i < 3; i++) cyc(2'd1, 0, 1, 777, 777, 0, 0);
      cyc(2'd1, 0, 1, 20, 20, 0, 0);
      close("vy_chg", 2'd1, 0, 0, 0, 0);
   endtask

   task automatic t_saturate();
      // R6: no state change in period
      for (int i = 0; i < 10; i++) cyc(2'd0, 0, 1, 500, 500, 0, 0);
      close("sat", 2'd0, 0, 0, 0, 0);
      // R6: state change but zero accepted samples
      cyc(2'd1, 0, 1, 5, 5, 1, 0);
      cyc(2'd1, 0, 1, 5, 5, 0, 0);
      close("zero_cnt", 2'd1, 0, 0, 0, 0);
   endtask

   task automatic t_count_limit();
      // R7 count stops at 1023; R8 equal words, opposite signs
      cyc(2'd0, 1, 1, 0, 0, 1, 0);
      for (int i = 0; i < 3; i++) cyc(2'd0, 1, 1, 0, 0, 0, 0);
      for (int i = 0; i < 1030; i++) cyc(2'd0, 1, 1, (i < CMAX) ? -9 : 30000, (i < CMAX) ? -9 : 30000, 0, 0);
      close("cnt_limit", 2'd0, 0, 0, 0, 0);
      check(res_a == -res_b, "R8 mirrored channels", res_a, -res_b);
      check(res_cnt == CMAX, "R7 count ceiling", res_cnt, CMAX);
   endtask

   initial begin
      #(4 * 150000);
      if (!done_flag) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_mixed();
      t_same_cycle();
      t_saturate();
      t_count_limit();
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule